// File: doc/BRIEF.md
# Register-Mapped Asynchronous Serial Port with FIFOs

This block is an asynchronous serial transmitter and receiver that software drives through a 32-byte register window. A write to the data register queues a character for transmission. A read of the data register takes the oldest received character. The error flags of that character are read afterwards from a separate status register. A 16x oversampling tick sets the bit rate and is derived from a 12-bit divisor. That divisor is split over a low register and the low nibble of a middle register. The frame shape, break forcing and the FIFO switch share one high line-control register. Two interrupt lines report receive data waiting and transmit space free.

Registers sit at word offsets. 0x00 is data, 0x04 is receive status, 0x08 is the high line control (frame, break, FIFO enable) and 0x0C is the middle line control (divisor bits 11:8 in bits 3:0). 0x10 is the low line control (divisor bits 7:0), 0x14 is control (bit 0 enables the port) and 0x18 is the flag register. An access whose address bits 1:0 are not zero hits nothing. Reads are combinational. A read of offset 0x00 pops the receive FIFO at the clock edge.

Top module: `fifo_uart`

## Requirements
- R1: After reset the flag register reads 0x10, txd is high, both interrupt lines are low and the control register reads 0.
- R2: One serial bit lasts exactly 16*(D+1) clock cycles, with D = {middle[3:0], low[7:0]}. Both divisor registers read back what was written.
- R3: A transmitted frame has these parts, in order:
  - a low start bit;
  - 5 + high[6:5] data bits, least significant first;
  - when high[1] is set, a parity bit (even when high[2] is set, odd when it is clear);
  - one high stop bit, or two when high[3] is set.
- R4: A frame of the same format received on rxd is stored right-aligned, with the unused upper bits zero. Reading offset 0x00 returns the oldest stored character and removes it.
- R5: The status register reports two errors. Bit 1 is set on a parity mismatch. Bit 0 is set when the first stop bit is sampled low. The receiver then waits for rxd to go high before it hunts for the next start bit.
- R6: A character that completes while the receive FIFO is full is discarded. Status bit 2 (overrun) is set on the newest stored entry.
- R7: With high[4] set, each direction holds 16 characters; with it clear, each holds one. A write to a full transmit FIFO is dropped. Flag bit 5 is transmit full, bit 4 is receive empty, and bit 3 is transmitter busy (a character is queued or being sent).
- R8: Setting high[0] drives txd low from the cycle after the write. Clearing it gives txd back to the transmitter.
- R9: rx_irq is high exactly while the receive FIFO holds data. tx_irq is high exactly while the port is enabled and the transmit FIFO is not full.
- R10: While control bit 0 is clear, nothing is sent or received, and queued transmit data is kept until the port is enabled.
- R11: The status register describes the character most recently popped. It changes only on the next pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 5 | Byte address within the register window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops the receive FIFO at offset 0x00) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| rx_irq | output | 1 | Receive data waiting |
| tx_irq | output | 1 | Transmit space available |

## Verification
The state that can go wrong is of three kinds: the tick counter, the per-frame sub-bit and bit counters, and the FIFO pointers and counts. A bad tick count shows up within the first start bit as a wrong low-pulse width on txd. A bad bit counter or format decode shows up within one frame as a wrong data, parity or stop level on txd. On the receive side it shows as a misaligned value at offset 0x00. A bad FIFO count or pointer only shows at the capacity boundary. There it gives a wrong full or empty flag, a lost or duplicated character, or an overrun mark on the wrong entry. Each of these is seen the first time the FIFO is filled to 16, or to 1 with the FIFO off.

// File: rtl/fifo_uart.sv
module fifo_uart #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       rxd,
  output logic       txd,
  output logic       rx_irq,
  output logic       tx_irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [2:0] A_DATA = 3'd0, A_RSTAT = 3'd1, A_LCRH = 3'd2, A_LCRM = 3'd3,
                         A_LCRL = 3'd4, A_CTRL = 3'd5, A_FLAG = 3'd6;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD} st_t;

  logic [6:0] lcr_h;
  logic [3:0] lcr_m;
  logic [7:0] lcr_l;
  logic       en;

  logic       hit;
  logic [2:0] sel;
  assign hit = bus_addr[1:0] == 2'b00;
  assign sel = bus_addr[4:2];

  logic       brk, par_en, par_even, stop2, fifo_en;
  logic [3:0] nbits;
  logic [7:0] dmask;
  logic [11:0] div;
  logic [CW-1:0] cap;
  assign brk      = lcr_h[0];
  assign par_en   = lcr_h[1];
  assign par_even = lcr_h[2];
  assign stop2    = lcr_h[3];
  assign fifo_en  = lcr_h[4];
  assign nbits    = 4'd5 + {2'b00, lcr_h[6:5]};
  assign dmask    = 8'hFF >> (4'd8 - nbits);
  assign div      = {lcr_m, lcr_l};
  assign cap      = fifo_en ? CW'(DEPTH) : CW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lcr_h <= '0; lcr_m <= '0; lcr_l <= '0; en <= 1'b0;
    end else if (bus_wr && hit) begin
      case (sel)
        A_LCRH:  lcr_h <= bus_wdata[6:0];
        A_LCRM:  lcr_m <= bus_wdata[3:0];
        A_LCRL:  lcr_l <= bus_wdata;
        A_CTRL:  en    <= bus_wdata[0];
        default: ;
      endcase
    end

  logic [11:0] div_cnt;
  logic        tick;
  assign tick = en && div_cnt == div;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div_cnt <= '0;
    else if (!en || tick) div_cnt <= '0;
    else div_cnt <= div_cnt + 12'd1;

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != 12'd0) |=> !tick);

  // transmit FIFO
  logic [7:0]    tx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp;
  logic [CW-1:0] tx_cnt;
  logic          tx_full, tx_push, tx_take;
  st_t           tx_st;
  assign tx_full = tx_cnt >= cap;
  assign tx_push = bus_wr && hit && sel == A_DATA && !tx_full;
  assign tx_take = tick && tx_st == S_IDLE && tx_cnt != '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) begin
        tx_mem[tx_wp] <= bus_wdata;
        tx_wp <= tx_wp + 1'b1;
      end
      if (tx_take) tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_take);
    end

  // R7
  tx_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH));

  // transmitter
  logic [3:0] tx_sub, tx_bit;
  logic [7:0] tx_sh;
  logic       tx_par, tx_line, tx_second;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_st <= S_IDLE; tx_sub <= '0; tx_bit <= '0; tx_sh <= '0;
      tx_par <= 1'b0; tx_line <= 1'b1; tx_second <= 1'b0;
    end else if (!en) begin
      tx_st <= S_IDLE; tx_line <= 1'b1;
    end else if (tick) begin
      if (tx_st == S_IDLE) begin
        if (tx_cnt != '0) begin
          tx_sh   <= tx_mem[tx_rp];
          tx_par  <= ^(tx_mem[tx_rp] & dmask) ^ ~par_even;
          tx_st   <= S_START;
          tx_sub  <= '0;
          tx_line <= 1'b0;
        end
      end else begin
        tx_sub <= tx_sub + 4'd1;
        if (tx_sub == 4'd15)
          case (tx_st)
            S_START: begin
              tx_st <= S_DATA; tx_bit <= '0; tx_line <= tx_sh[0];
            end
            S_DATA:
              if (tx_bit == nbits - 4'd1) begin
                if (par_en) begin
                  tx_st <= S_PAR; tx_line <= tx_par;
                end else begin
                  tx_st <= S_STOP; tx_line <= 1'b1; tx_second <= stop2;
                end
              end else begin
                tx_bit <= tx_bit + 4'd1;
                tx_sh <= tx_sh >> 1;
                tx_line <= tx_sh[1];
              end
            S_PAR: begin
              tx_st <= S_STOP; tx_line <= 1'b1; tx_second <= stop2;
            end
            S_STOP:
              if (tx_second) tx_second <= 1'b0;
              else tx_st <= S_IDLE;
            default: tx_st <= S_IDLE;
          endcase
      end
    end

  assign txd = brk ? 1'b0 : tx_line;

  // R10
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (tx_st == S_IDLE && tx_line));

  // R3
  tx_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_st == S_IDLE && !brk) |-> txd);

  // receiver
  logic       rx_s1, rx_s2, rx_pbit;
  st_t        rx_st;
  logic [3:0] rx_sub, rx_bit;
  logic [7:0] rx_sh, rx_word;
  logic       rx_done, rx_perr;
  assign rx_word = rx_sh >> (4'd8 - nbits);
  assign rx_done = tick && rx_st == S_STOP && rx_sub == 4'd7;
  assign rx_perr = par_en && (rx_pbit != (^rx_word ^ ~par_even));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_s1 <= 1'b1; rx_s2 <= 1'b1; rx_st <= S_IDLE; rx_sub <= '0;
      rx_bit <= '0; rx_sh <= '0; rx_pbit <= 1'b0;
    end else begin
      rx_s1 <= rxd;
      rx_s2 <= rx_s1;
      if (!en) begin
        rx_st <= S_IDLE; rx_sub <= '0;
      end else if (rx_st == S_HOLD) begin
        if (rx_s2) rx_st <= S_IDLE;
      end else if (tick) begin
        if (rx_st == S_IDLE) begin
          if (!rx_s2) begin
            rx_st <= S_START; rx_sub <= '0;
          end
        end else begin
          rx_sub <= rx_sub + 4'd1;
          if (rx_sub == 4'd7)
            case (rx_st)
              S_START: if (rx_s2) rx_st <= S_IDLE;
              S_DATA:  rx_sh <= {rx_s2, rx_sh[7:1]};
              S_PAR:   rx_pbit <= rx_s2;
              S_STOP:  rx_st <= rx_s2 ? S_IDLE : S_HOLD;
              default: ;
            endcase
          if (rx_sub == 4'd15)
            case (rx_st)
              S_START: begin rx_st <= S_DATA; rx_bit <= '0; end
              S_DATA:
                if (rx_bit == nbits - 4'd1) rx_st <= par_en ? S_PAR : S_STOP;
                else rx_bit <= rx_bit + 4'd1;
              S_PAR:   rx_st <= S_STOP;
              default: ;
            endcase
        end
      end
    end

  // receive FIFO: {overrun, parity, framing, data}
  logic [10:0]   rx_mem [DEPTH];
  logic [AW-1:0] rx_wp, rx_rp, rx_last;
  logic [CW-1:0] rx_cnt;
  logic          rx_full, rx_push, rx_pop;
  logic [2:0]    last_stat;
  assign rx_last = rx_wp - 1'b1;
  assign rx_full = rx_cnt >= cap;
  assign rx_push = rx_done && !rx_full;
  assign rx_pop  = bus_rd && hit && sel == A_DATA && rx_cnt != '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0; last_stat <= '0;
    end else begin
      if (rx_push) begin
        rx_mem[rx_wp] <= {1'b0, rx_perr, ~rx_s2, rx_word};
        rx_wp <= rx_wp + 1'b1;
      end else if (rx_done && rx_cnt != '0)
        rx_mem[rx_last][10] <= 1'b1;
      if (rx_pop) begin
        rx_rp <= rx_rp + 1'b1;
        last_stat <= rx_mem[rx_rp][10:8];
      end
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end

  // R6
  rx_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH));

  // R9
  rx_irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && rx_cnt == CW'(1) && !rx_done) |=> !rx_irq);

  assign rx_irq = rx_cnt != '0;
  assign tx_irq = en && !tx_full;

  logic busy;
  assign busy = tx_st != S_IDLE || tx_cnt != '0;

  always_comb begin
    bus_rdata = '0;
    if (hit)
      case (sel)
        A_DATA:  bus_rdata = rx_cnt != '0 ? rx_mem[rx_rp][7:0] : 8'h00;
        A_RSTAT: bus_rdata = {5'b0, last_stat};
        A_LCRH:  bus_rdata = {1'b0, lcr_h};
        A_LCRM:  bus_rdata = {4'b0, lcr_m};
        A_LCRL:  bus_rdata = lcr_l;
        A_CTRL:  bus_rdata = {7'b0, en};
        A_FLAG:  bus_rdata = {2'b0, tx_full, rx_cnt == '0, busy, 3'b0};
        default: bus_rdata = '0;
      endcase
  end
endmodule

// File: tb/fifo_uart_test.sv
module fifo_uart_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       rxd = 1'b1;
  logic       txd, rx_irq, tx_irq;

  fifo_uart uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
                 .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
                 .rxd(rxd), .txd(txd), .rx_irq(rx_irq), .tx_irq(tx_irq));

  always #2 clk = ~clk;

  int nchk = 0, nfail = 0, bt = 16;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic cfg(input int dv, input logic [7:0] lh);
    wr(5'h14, 8'h00);
    wr(5'h10, dv[7:0]);
    wr(5'h0C, {4'b0, dv[11:8]});
    wr(5'h08, lh);
    wr(5'h14, 8'h01);
    bt = 16 * (dv + 1);
  endtask

  task automatic send_rx(input logic [7:0] b, input int nb, input bit pe, input bit ev,
                         input bit two, input bit badp, input bit bads);
    logic [7:0] m;
    m = 8'hFF >> (8 - nb);
    rxd = 1'b0; repeat (bt) @(negedge clk);
    for (int i = 0; i < nb; i++) begin rxd = b[i]; repeat (bt) @(negedge clk); end
    if (pe) begin rxd = (^(b & m)) ^ !ev ^ badp; repeat (bt) @(negedge clk); end
    rxd = !bads; repeat (bt) @(negedge clk);
    rxd = 1'b1;
    if (two || bads) repeat (bt) @(negedge clk);
  endtask

  task automatic cap_tx(input int nb, input bit pe, input bit two,
                        output logic [7:0] d, output logic p, output logic s1, output logic s2);
    int t;
    t = 0; d = '0; p = 1'b0; s1 = 1'b0; s2 = 1'b1;
    while (txd !== 1'b0 && t < 60000) begin @(negedge clk); t++; end
    if (t >= 60000) begin chk(1'b0, "R3 no start bit", t, 0); return; end
    repeat (bt / 2) @(negedge clk);
    for (int i = 0; i < nb; i++) begin repeat (bt) @(negedge clk); d[i] = txd; end
    if (pe) begin repeat (bt) @(negedge clk); p = txd; end
    repeat (bt) @(negedge clk); s1 = txd;
    if (two) begin repeat (bt) @(negedge clk); s2 = txd; end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [7:0] r, d, m, b;
    logic p, s1, s2;
    int w, nb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(5'h18, r); chk(r == 8'h10, "R1 flags", r, 8'h10);
    rd(5'h14, r); chk(r == 8'h00, "R1 control", r, 0);
    chk(txd == 1'b1 && rx_irq == 1'b0 && tx_irq == 1'b0, "R1 pins",
        {txd, rx_irq, tx_irq}, 3'b100);

    // R3 R4 sweep over every frame format
    for (int wl = 0; wl < 4; wl++)
      for (int pm = 0; pm < 3; pm++)
        for (int s = 0; s < 2; s++) begin
          nb = 5 + wl;
          m = 8'hFF >> (8 - nb);
          cfg((wl + pm + s) % 2, {1'b0, wl[1:0], 1'b1, s[0], pm == 2, pm != 0, 1'b0});
          b = 8'(8'h5A + wl * 53 + pm * 17 + s * 101);
          wr(5'h00, b);
          cap_tx(nb, pm != 0, s != 0, d, p, s1, s2);
          chk(d == (b & m), "R3 tx data", d, b & m);
          if (pm != 0) chk(p == ((^(b & m)) ^ (pm == 1)), "R3 tx parity", p, (^(b & m)) ^ (pm == 1));
          chk(s1 && s2, "R3 tx stop", {s1, s2}, 2'b11);
          send_rx(~b, nb, pm != 0, pm == 2, s != 0, 1'b0, 1'b0);
          rd(5'h00, r); chk(r == (~b & m), "R4 rx data", r, ~b & m);
          rd(5'h04, r); chk(r == 8'h00, "R5 clean status", r, 0);
        end

    // R2 bit period
    cfg(2, 8'h70);
    wr(5'h00, 8'h01);
    while (txd !== 1'b0) @(negedge clk);
    w = 0;
    while (txd === 1'b0 && w < 20000) begin w++; @(negedge clk); end
    chk(w == 48, "R2 period div=2", w, 48);
    repeat (10 * bt) @(negedge clk);
    cfg(12'h105, 8'h70);
    rd(5'h0C, r); chk(r == 8'h01, "R2 middle readback", r, 1);
    rd(5'h10, r); chk(r == 8'h05, "R2 low readback", r, 5);
    wr(5'h00, 8'h01);
    while (txd !== 1'b0) @(negedge clk);
    w = 0;
    while (txd === 1'b0 && w < 20000) begin w++; @(negedge clk); end
    chk(w == 16 * 262, "R2 period div=0x105", w, 16 * 262);
    repeat (10 * bt) @(negedge clk);

    // R5 parity and framing errors, R11 status follows pops
    cfg(0, 8'h76);
    send_rx(8'h3C, 8, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    send_rx(8'hC3, 8, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    send_rx(8'h81, 8, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    rd(5'h00, r); chk(r == 8'h3C, "R5 data with parity error", r, 8'h3C);
    rd(5'h04, r); chk(r == 8'h02, "R5 parity bit1", r, 2);
    rd(5'h04, r); chk(r == 8'h02, "R11 status held between pops", r, 2);
    rd(5'h00, r); chk(r == 8'hC3, "R5 data with framing error", r, 8'hC3);
    rd(5'h04, r); chk(r == 8'h01, "R5 framing bit0", r, 1);
    rd(5'h00, r); chk(r == 8'h81, "R5 recovery after framing error", r, 8'h81);
    rd(5'h04, r); chk(r == 8'h00, "R11 status of latest pop", r, 0);

    // R6 R7 R9 overrun with 16-entry FIFO
    cfg(0, 8'h70);
    for (int i = 0; i < 17; i++) send_rx(8'(i + 8'h20), 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(rx_irq == 1'b1, "R9 rx_irq with data", rx_irq, 1);
    for (int i = 0; i < 16; i++) begin
      rd(5'h00, r); chk(r == 8'(i + 8'h20), "R6 R7 fifo order", r, i + 8'h20);
      rd(5'h04, r); chk(r == ((i == 15) ? 8'h04 : 8'h00), "R6 overrun mark", r, (i == 15) ? 4 : 0);
    end
    rd(5'h18, r); chk(r[4] == 1'b1, "R6 extra char discarded", r, 8'h10);
    chk(rx_irq == 1'b0, "R9 rx_irq cleared", rx_irq, 0);

    // R6 R7 single-entry holding register
    cfg(0, 8'h60);
    send_rx(8'h11, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    send_rx(8'h22, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    rd(5'h00, r); chk(r == 8'h11, "R7 single entry keeps first", r, 8'h11);
    rd(5'h04, r); chk(r == 8'h04, "R6 overrun single entry", r, 4);
    rd(5'h18, r); chk(r[4] == 1'b1, "R7 single entry empty", r, 8'h10);

    // R7 R9 R10 transmit FIFO full while disabled
    cfg(0, 8'h70);
    wr(5'h14, 8'h00);
    for (int i = 0; i < 17; i++) wr(5'h00, 8'(8'h40 + i));
    rd(5'h18, r); chk(r == 8'h38, "R7 tx full and busy", r, 8'h38);
    chk(tx_irq == 1'b0, "R9 tx_irq low when disabled", tx_irq, 0);
    w = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (txd !== 1'b1) w++; end
    chk(w == 0, "R10 no transmission while disabled", w, 0);
    send_rx(8'h77, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    rd(5'h18, r); chk(r[4] == 1'b1, "R10 no reception while disabled", r, 8'h38);
    wr(5'h14, 8'h01);
    chk(tx_irq == 1'b0, "R9 tx_irq low when full", tx_irq, 0);
    for (int i = 0; i < 16; i++) begin
      cap_tx(8, 1'b0, 1'b0, d, p, s1, s2);
      chk(d == 8'(8'h40 + i), "R7 R10 held data order", d, 8'h40 + i);
    end
    repeat (3 * bt) @(negedge clk);
    rd(5'h18, r); chk(r == 8'h10, "R7 drained, 17th dropped", r, 8'h10);
    chk(tx_irq == 1'b1, "R9 tx_irq with space", tx_irq, 1);

    // R7 single-entry transmit holding register
    cfg(0, 8'h60);
    wr(5'h14, 8'h00);
    wr(5'h00, 8'h9A);
    rd(5'h18, r); chk(r[5] == 1'b1, "R7 single tx entry full", r, 8'h38);
    wr(5'h00, 8'h55);
    wr(5'h14, 8'h01);
    cap_tx(8, 1'b0, 1'b0, d, p, s1, s2);
    chk(d == 8'h9A, "R7 single tx entry data", d, 8'h9A);
    repeat (3 * bt) @(negedge clk);
    rd(5'h18, r); chk(r[3] == 1'b0, "R7 second write dropped", r, 8'h10);

    // R8 break
    cfg(0, 8'h70);
    wr(5'h08, 8'h71);
    chk(txd == 1'b0, "R8 break low", txd, 0);
    repeat (40) @(negedge clk);
    chk(txd == 1'b0, "R8 break held", txd, 0);
    wr(5'h08, 8'h70);
    chk(txd == 1'b1, "R8 break released", txd, 1);

    finish_run();
  end
endmodule